// File: doc/BRIEF.md
# Host Serial Command Port

A three-wire control port lets a host microcontroller load settings into an audio processing core. The host supplies a data line, a shift clock and a latch strobe. All three are asynchronous to the system clock. The block synchronises them, detects the rising edges of the shift clock and the latch, and collects the data bits into a 26-bit shift register.

Bits arrive least significant first. Each new bit enters the top of the register, and the register shifts right. A 16-bit command and a 26-bit command therefore both end up aligned to the top bit. On the latch edge the top bits select one of four command kinds:

- an operating-mode word,
- a processing-function word,
- an output level,
- a coefficient memory write.

Mode, function and level updates wait in a pending slot and take effect at the next sample-rate tick. Memory writes wait in a small queue. The queue issues at most one write per tick.

Top module: `host_cmd_port`

## Requirements
- R1: The block samples the data line at each rising shift-clock edge and shifts the sample into bit 25 of a register that shifts right. A rising latch edge takes the register as the command and then clears the register. A 16-bit command and a 26-bit command decode alike, and only their top bits carry the kind and fields.
- R2: When bits 25..22 are 0010, the block stores bits 21..10 as a pending mode word. `mode_o[11:0]` takes that word, with bit 21 in `mode_o[11]`, at the next cycle that has `fs_tick_i` high.
- R3: When bits 25..22 are 0011, the block stores bits 21..10 as a pending function word. `func_o` takes that word at the next tick.
- R4: When bits 25..24 are 01, the block stores bits 23..10 as a pending level. `atten_o[13:0]` takes that level at the next tick.
- R5: When bit 25 is 1, the block queues a memory write, with the address in bits 24..18 and the data in bits 17..0. At a tick with a non-empty queue, `ram_we_o` is high for the following cycle only, and it carries the oldest entry on `ram_addr_o` and `ram_data_o`. Entries leave in arrival order, one per tick. `ram_addr_o` and `ram_data_o` hold their values between writes.
- R6: `wq_full_o` is high while the queue holds Q_DEPTH entries (default 4). A write command that arrives while the queue is full is discarded.
- R7: `gp_o` follows `func_o[3]`, which is bit 13 of the function command.
- R8: Reset sets the mode, function and level outputs to 0, sets `gp_o` to 0, clears `ram_we_o` and the address and data outputs, and empties the queue.
- R9: A command whose bits 25..22 are 0000 or 0001 changes no output, including at later ticks.
- R10: Between ticks, the outputs hold. A second command of the same kind that arrives before a tick replaces the pending value, so only the latest value reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdat_i | input | 1 | Host serial data |
| sclk_i | input | 1 | Host shift clock |
| slat_i | input | 1 | Host latch strobe |
| fs_tick_i | input | 1 | One-cycle pulse at the start of each sample period |
| mode_o | output | 12 | Applied mode word |
| func_o | output | 12 | Applied function word |
| atten_o | output | 14 | Applied output level |
| gp_o | output | 1 | General-purpose output bit |
| ram_we_o | output | 1 | Coefficient memory write strobe |
| ram_addr_o | output | 7 | Coefficient memory write address |
| ram_data_o | output | 18 | Coefficient memory write data |
| wq_full_o | output | 1 | Write queue full |

## Verification
The hardest state to reach from the ports is a full write queue that then receives one more write command. To get there, the stimulus sends five full-length write commands in a row with no tick between them. It then drains the queue one tick at a time, which shows that the fifth write was lost and that the other four leave in order. A 16-bit level command is followed by a 26-bit level command whose low bits carry junk, so the alignment is tested at both lengths. Two mode commands before a single tick test the replacement of a pending value.

// File: rtl/host_cmd_pkg.sv
package host_cmd_pkg;
  localparam int CMD_W  = 26;
  localparam int FLD_W  = 12;
  localparam int ATT_W  = 14;
  localparam int RA_W   = 7;
  localparam int RD_W   = 18;
  localparam int WR_W   = RA_W + RD_W;
  localparam int FLD_LO = 10;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_MODE,
    CK_FUNC,
    CK_ATT,
    CK_RAM
  } cmd_kind_e;
endpackage

// File: rtl/host_sync.sv
module host_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      prev_q <= '0;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign q_o    = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cmd_shift.sv
module cmd_shift
  import host_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             shift_i,
  input  logic             latch_i,
  output logic             vld_o,
  output cmd_kind_e        kind_o,
  output logic [CMD_W-1:0] word_o
);
  logic [CMD_W-1:0] sr_q;
  cmd_kind_e        kind_d;

  always_comb begin
    if (sr_q[CMD_W-1])                    kind_d = CK_RAM;
    else if (sr_q[CMD_W-2])               kind_d = CK_ATT;
    else if (sr_q[CMD_W-3:CMD_W-4] == 2'b10) kind_d = CK_MODE;
    else if (sr_q[CMD_W-3:CMD_W-4] == 2'b11) kind_d = CK_FUNC;
    else                                  kind_d = CK_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      vld_o  <= 1'b0;
      kind_o <= CK_NONE;
      word_o <= '0;
    end else begin
      vld_o <= latch_i;
      if (latch_i) begin
        word_o <= sr_q;
        kind_o <= kind_d;
        sr_q   <= '0;
      end else if (shift_i) begin
        sr_q <= {bit_i, sr_q[CMD_W-1:1]};
      end
    end
  end
endmodule

// File: rtl/wr_queue.sv
module wr_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 25
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic         we_o,
  output logic [W-1:0] dout_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      we_o   <= 1'b0;
      dout_o <= '0;
    end else begin
      we_o <= pop_ok;
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok) begin
        rd_q   <= nxt(rd_q);
        dout_o <= mem[rd_q];
      end
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/host_cmd_port.sv
module host_cmd_port
  import host_cmd_pkg::*;
#(
  parameter int Q_DEPTH     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdat_i,
  input  logic             sclk_i,
  input  logic             slat_i,
  input  logic             fs_tick_i,
  output logic [FLD_W-1:0] mode_o,
  output logic [FLD_W-1:0] func_o,
  output logic [ATT_W-1:0] atten_o,
  output logic             gp_o,
  output logic             ram_we_o,
  output logic [RA_W-1:0]  ram_addr_o,
  output logic [RD_W-1:0]  ram_data_o,
  output logic             wq_full_o
);
  localparam int GP_BIT = 3;

  logic [2:0]       pin_q, pin_rise;
  logic             cmd_vld;
  cmd_kind_e        cmd_kind;
  logic [CMD_W-1:0] cmd_word;
  logic [WR_W-1:0]  q_dout;

  logic [FLD_W-1:0] mode_p, func_p;
  logic [ATT_W-1:0] att_p;
  logic             mode_pv, func_pv, att_pv;

  host_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk_i, .rst_ni,
    .d_i   ({slat_i, sclk_i, sdat_i}),
    .q_o   (pin_q),
    .rise_o(pin_rise)
  );

  cmd_shift u_shift (
    .clk_i, .rst_ni,
    .bit_i  (pin_q[0]),
    .shift_i(pin_rise[1]),
    .latch_i(pin_rise[2]),
    .vld_o  (cmd_vld),
    .kind_o (cmd_kind),
    .word_o (cmd_word)
  );

  wr_queue #(.DEPTH(Q_DEPTH), .W(WR_W)) u_queue (
    .clk_i, .rst_ni,
    .push_i(cmd_vld && cmd_kind == CK_RAM),
    .din_i (cmd_word[WR_W-1:0]),
    .pop_i (fs_tick_i),
    .we_o  (ram_we_o),
    .dout_o(q_dout),
    .full_o(wq_full_o)
  );

  assign ram_addr_o = q_dout[WR_W-1:RD_W];
  assign ram_data_o = q_dout[RD_W-1:0];

  // tick applies the old pending value; a same-cycle latch re-arms the slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= '0; func_o  <= '0; atten_o <= '0;
      mode_p  <= '0; func_p  <= '0; att_p   <= '0;
      mode_pv <= 1'b0; func_pv <= 1'b0; att_pv <= 1'b0;
    end else begin
      if (fs_tick_i) begin
        if (mode_pv) mode_o  <= mode_p;
        if (func_pv) func_o  <= func_p;
        if (att_pv)  atten_o <= att_p;
        mode_pv <= 1'b0;
        func_pv <= 1'b0;
        att_pv  <= 1'b0;
      end
      if (cmd_vld) begin
        unique case (cmd_kind)
          CK_MODE: begin mode_p <= cmd_word[FLD_LO+:FLD_W]; mode_pv <= 1'b1; end
          CK_FUNC: begin func_p <= cmd_word[FLD_LO+:FLD_W]; func_pv <= 1'b1; end
          CK_ATT:  begin att_p  <= cmd_word[FLD_LO+:ATT_W]; att_pv  <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  assign gp_o = func_o[GP_BIT];
endmodule

// File: rtl/host_cmd_port_chk.sv
module host_cmd_port_chk
  import host_cmd_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fs_tick_i,
  input logic [FLD_W-1:0] mode_o,
  input logic [FLD_W-1:0] func_o,
  input logic [ATT_W-1:0] atten_o,
  input logic             ram_we_o,
  input logic             wq_full_o
);
  assert_mode_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_tick_i |=> $stable(mode_o));
  assert_func_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_tick_i |=> $stable(func_o));
  assert_att_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_tick_i |=> $stable(atten_o));
  assert_we_after_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> $past(fs_tick_i));
  assert_full_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wq_full_o && !fs_tick_i |=> wq_full_o);
endmodule

bind host_cmd_port host_cmd_port_chk u_chk (.*);

// File: tb/host_cmd_port_bench.sv
`timescale 1ns/1ps
module host_cmd_port_bench;
  logic clk = 0, rst_n = 0;
  logic sdat = 0, sclk = 0, slat = 0, tick = 0;
  logic [11:0] mode_o, func_o;
  logic [13:0] atten_o;
  logic gp_o, ram_we_o, wq_full_o;
  logic [6:0] ram_addr_o;
  logic [17:0] ram_data_o;

  always #2.5 clk = ~clk;

  host_cmd_port u_host_cmd_port (
    .clk_i(clk), .rst_ni(rst_n), .sdat_i(sdat), .sclk_i(sclk), .slat_i(slat),
    .fs_tick_i(tick), .mode_o, .func_o, .atten_o, .gp_o, .ram_we_o,
    .ram_addr_o, .ram_data_o, .wq_full_o
  );

  int nchk = 0, nfail = 0;
  bit busy = 1, done = 0;

  // reference model
  logic [11:0] em_mode, em_func, pm, pf;
  logic [13:0] em_att, pa;
  bit pmv, pfv, pav;
  logic em_we;
  logic [6:0] em_addr;
  logic [17:0] em_data;
  logic [24:0] q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_cmd(input logic [25:0] w);
    if (w[25]) begin
      if (q.size() < 4) q.push_back(w[24:0]);
    end else if (w[24]) begin
      pa = w[23:10]; pav = 1;
    end else if (w[23:22] == 2'b10) begin
      pm = w[21:10]; pmv = 1;
    end else if (w[23:22] == 2'b11) begin
      pf = w[21:10]; pfv = 1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      em_mode <= 0; em_func <= 0; em_att <= 0; em_we <= 0; em_addr <= 0; em_data <= 0;
      pmv = 0; pfv = 0; pav = 0; q.delete();
    end else begin
      em_we <= 0;
      if (tick) begin
        if (pmv) em_mode <= pm;
        if (pfv) em_func <= pf;
        if (pav) em_att <= pa;
        pmv = 0; pfv = 0; pav = 0;
        if (q.size() > 0) begin
          logic [24:0] e;
          e = q.pop_front();
          em_we <= 1; em_addr <= e[24:18]; em_data <= e[17:0];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !busy && !done) begin
      chk("R2 mode", mode_o, em_mode);
      chk("R3 func", func_o, em_func);
      chk("R4 atten", atten_o, em_att);
      chk("R7 gp", gp_o, em_func[3]);
      chk("R5 we", ram_we_o, em_we);
      chk("R5 addr", ram_addr_o, em_addr);
      chk("R5 data", ram_data_o, em_data);
      chk("R6 full", wq_full_o, q.size() == 4);
    end
  end

  task automatic send(input logic [25:0] w, input int n);
    busy = 1;
    for (int i = 26 - n; i < 26; i++) begin
      sdat = w[i];
      repeat (2) @(negedge clk);
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
      repeat (2) @(negedge clk);
    end
    slat = 1;
    repeat (4) @(negedge clk);
    slat = 0;
    repeat (4) @(negedge clk);
    model_cmd(w);
    @(negedge clk);
    busy = 0;
  endtask

  task automatic fs_tick();
    tick = 1;
    @(negedge clk);
    tick = 0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [25:0] mk(input logic [3:0] top, input logic [11:0] f);
    return {top, f, 10'h000};
  endfunction

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    chk("R8 mode", mode_o, 0); chk("R8 func", func_o, 0); chk("R8 atten", atten_o, 0);
    chk("R8 gp", gp_o, 0); chk("R8 we", ram_we_o, 0); chk("R8 full", wq_full_o, 0);
    chk("R8 addr", ram_addr_o, 0); chk("R8 data", ram_data_o, 0);
    busy = 0;

    // R2 mode via 16 bits, R10 held until tick
    send(mk(4'b0010, 12'hA5C), 16);
    chk("R10 mode before tick", mode_o, 0);
    fs_tick();
    chk("R2 mode applied", mode_o, 12'hA5C);

    // R3 + R7
    send(mk(4'b0011, 12'h008), 16);
    fs_tick();
    chk("R3 func", func_o, 12'h008);
    chk("R7 gp high", gp_o, 1);
    send(mk(4'b0011, 12'hFF7), 16);
    fs_tick();
    chk("R7 gp low", gp_o, 0);

    // R1/R4: 16-bit level, then 26-bit level with junk low bits
    send({2'b01, 14'h2D4E, 10'h000}, 16);
    fs_tick();
    chk("R4 atten 16b", atten_o, 14'h2D4E);
    send({2'b01, 14'h0013, 10'h3FF}, 26);
    fs_tick();
    chk("R1 atten 26b aligned", atten_o, 14'h0013);

    // R9 ignored codes
    send(mk(4'b0000, 12'hFFF), 16);
    send(mk(4'b0001, 12'h123), 26);
    fs_tick();
    chk("R9 mode unchanged", mode_o, 12'hA5C);
    chk("R9 func unchanged", func_o, 12'hFF7);
    chk("R9 atten unchanged", atten_o, 14'h0013);

    // R10 replacement
    send(mk(4'b0010, 12'h111), 16);
    send(mk(4'b0010, 12'h3C3), 16);
    fs_tick();
    chk("R10 last mode wins", mode_o, 12'h3C3);

    // R5/R6 queue fill and overflow
    for (int k = 0; k < 5; k++)
      send({1'b1, 7'(k * 17 + 3), 18'(k * 4099 + 7)}, 26);
    chk("R6 full after 4", wq_full_o, 1);
    for (int k = 0; k < 4; k++) begin
      tick = 1;
      @(negedge clk);
      tick = 0;
      chk("R5 we", ram_we_o, 1);
      chk("R5 addr order", ram_addr_o, 7'(k * 17 + 3));
      chk("R5 data order", ram_data_o, 18'(k * 4099 + 7));
      @(negedge clk);
      chk("R5 we one cycle", ram_we_o, 0);
      repeat (2) @(negedge clk);
    end
    chk("R6 not full", wq_full_o, 0);
    tick = 1;
    @(negedge clk);
    tick = 0;
    chk("R6 fifth write dropped", ram_we_o, 0);
    chk("R5 addr held", ram_addr_o, 7'(3 * 17 + 3));
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule